// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Page Permissions

This block is a small fully associative translation buffer. It turns virtual addresses into physical addresses and checks each access against rights stored for the page. A lookup presents a virtual address and an access kind: read, write or execute. One clock later the block returns exactly one of three outcomes: a hit carrying the physical address, a miss, or a protection fault. Privileged software fills the buffer through an install port that writes a whole entry at an index software chooses. The block never walks a page table. A miss is only reported, and software handles it as a trap.

Each entry holds a virtual page tag, a physical frame number, a valid flag, three rights flags, a dirty flag and a referenced flag. A lookup that is allowed marks the entry as referenced, and it also marks the entry dirty when the access is a write. These two flags let software choose a page to evict and decide whether that page must be written back. Software can clear every referenced flag in one cycle to sample page usage. A status probe port reads back the dirty and referenced flags of any entry.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid, every dirty and referenced flag is 0, and every response output is 0.
- R2: A lookup that matches a valid entry and is allowed gives rsp_valid=1, rsp_hit=1 and rsp_paddr = {frame number, vaddr[9:0]} in the cycle after the request edge. The page offset is the low 10 bits.
- R3: When no valid entry has a tag equal to vaddr[14:10], the response is rsp_miss=1 with rsp_hit=0, rsp_fault=0 and rsp_paddr=0.
- R4: The rights field has bit 0 = read, bit 1 = write and bit 2 = execute. lk_kind is 0 for read, 1 for write, 2 for execute, and 3 is never allowed. A matching access whose right bit is 0 gives rsp_fault=1 with rsp_hit=0 and rsp_paddr=0.
- R5: An allowed write lookup sets the dirty flag of the matched entry. Allowed reads and executes leave it unchanged.
- R6: Every allowed lookup sets the referenced flag of the matched entry.
- R7: A lookup that faults changes no dirty or referenced flag.
- R8: A cycle with clr_ref=1 clears every referenced flag. This overrides an allowed lookup that would set one in the same cycle.
- R9: When several valid entries carry the same tag, the entry with the lowest index provides the translation and receives the flag updates.
- R10: An install writes tag, frame, valid and rights at wr_idx and clears that entry's dirty and referenced flags. A lookup in the same cycle sees the old contents, and the install overrides that lookup's flag update on the same index.
- R11: rsp_valid is 1 exactly in the cycle after a cycle with lk_req=1. Otherwise all three outcome flags are 0, and whenever rsp_valid is 1 exactly one of them is 1.
- R12: rd_dirty and rd_ref show the flags of entry rd_idx as they stood before the previous edge, one cycle after rd_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 15 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No valid matching entry (software trap) |
| rsp_fault | output | 1 | Access not permitted by rights |
| rsp_paddr | output | 13 | Physical address on hit, else 0 |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | 3 | Entry index to install |
| wr_vpn | input | 5 | Virtual page tag to install |
| wr_ppn | input | 3 | Physical frame to install |
| wr_valid | input | 1 | Valid flag to install |
| wr_rights | input | 3 | Rights to install (bit0 R, bit1 W, bit2 X) |
| clr_ref | input | 1 | Clear all referenced flags |
| rd_idx | input | 3 | Entry whose flags are probed |
| rd_dirty | output | 1 | Dirty flag of probed entry |
| rd_ref | output | 1 | Referenced flag of probed entry |

## Verification
Lookups are issued against addresses with no entry, with an invalidated entry, and with valid entries, so that misses can be told apart from hits and the offset can be seen passing through unchanged. Every access kind is tried against read-only, read/write, execute-only and empty rights, which shows whether each right bit guards exactly its own access kind and whether a faulting access leaves the flags untouched. Duplicate tags, a clear in the same cycle as a hit, and an install in the same cycle as a hit on the same index show the priority between competing updates. A behavioural model steps alongside the design every clock and compares all outputs, while random traffic in between covers combinations that the directed cases do not reach.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;
  localparam int RIGHTS_W = 3;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              vpn,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = valid[g] && (tags[g] == vpn);
    end
  endgenerate

  // lowest index wins: scan from the top so the lowest match is written last
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

  assign found = |eq;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import soft_tlb_pkg::*;
(
  input  logic [RIGHTS_W-1:0] rights,
  input  logic [1:0]          kind,
  output logic                allow
);
  always_comb begin
    case (acc_kind_e'(kind))
      ACC_READ:  allow = rights[RIGHT_R];
      ACC_WRITE: allow = rights[RIGHT_W];
      ACC_EXEC:  allow = rights[RIGHT_X];
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 5,
  parameter int PPN_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [VPN_W-1:0]                 wr_vpn,
  input  logic [PPN_W-1:0]                 wr_ppn,
  input  logic                             wr_valid,
  input  logic [RIGHTS_W-1:0]              wr_rights,
  input  logic                             upd_en,
  input  logic [IDX_W-1:0]                 upd_idx,
  input  logic                             upd_dirty,
  input  logic                             clr_ref,
  output logic [ENTRIES-1:0]               valid_q,
  output logic [ENTRIES-1:0][VPN_W-1:0]    tag_q,
  output logic [ENTRIES-1:0][PPN_W-1:0]    ppn_q,
  output logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_q,
  output logic [ENTRIES-1:0]               dirty_q,
  output logic [ENTRIES-1:0]               ref_q
);
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      logic inst_here, upd_here;
      assign inst_here = wr_en && (wr_idx == IDX_W'(g));
      assign upd_here  = upd_en && (upd_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[g]  <= 1'b0;
          tag_q[g]    <= '0;
          ppn_q[g]    <= '0;
          rights_q[g] <= '0;
          dirty_q[g]  <= 1'b0;
          ref_q[g]    <= 1'b0;
        end else if (inst_here) begin
          valid_q[g]  <= wr_valid;
          tag_q[g]    <= wr_vpn;
          ppn_q[g]    <= wr_ppn;
          rights_q[g] <= wr_rights;
          dirty_q[g]  <= 1'b0;
          ref_q[g]    <= 1'b0;
        end else begin
          if (upd_here && upd_dirty) dirty_q[g] <= 1'b1;
          if (clr_ref)               ref_q[g]   <= 1'b0;
          else if (upd_here)         ref_q[g]   <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int VA_W    = 15,
  parameter int PA_W    = 13,
  parameter int OFF_W   = 10,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_req,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic [1:0]          lk_kind,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_fault,
  output logic [PA_W-1:0]     rsp_paddr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic                wr_valid,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic                clr_ref,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_dirty,
  output logic                rd_ref
);
  logic [ENTRIES-1:0]               valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]    tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0]    ppn_q;
  logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_q;
  logic [ENTRIES-1:0]               dirty_q;
  logic [ENTRIES-1:0]               ref_q;

  logic             found, allow, upd_en;
  logic [IDX_W-1:0] sel;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid (valid_q),
    .tags  (tag_q),
    .vpn   (lk_vaddr[VA_W-1:OFF_W]),
    .found (found),
    .idx   (sel)
  );

  tlb_perm u_perm (
    .rights (rights_q[sel]),
    .kind   (lk_kind),
    .allow  (allow)
  );

  assign upd_en = lk_req && found && allow;

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_vpn    (wr_vpn),
    .wr_ppn    (wr_ppn),
    .wr_valid  (wr_valid),
    .wr_rights (wr_rights),
    .upd_en    (upd_en),
    .upd_idx   (sel),
    .upd_dirty (lk_kind == ACC_WRITE),
    .clr_ref   (clr_ref),
    .valid_q   (valid_q),
    .tag_q     (tag_q),
    .ppn_q     (ppn_q),
    .rights_q  (rights_q),
    .dirty_q   (dirty_q),
    .ref_q     (ref_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rd_dirty  <= 1'b0;
      rd_ref    <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= upd_en;
      rsp_miss  <= lk_req && !found;
      rsp_fault <= lk_req && found && !allow;
      rsp_paddr <= upd_en ? {ppn_q[sel], lk_vaddr[OFF_W-1:0]} : '0;
      rd_dirty  <= dirty_q[rd_idx];
      rd_ref    <= ref_q[rd_idx];
    end
  end
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int PA_W    = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_req,
  input logic               wr_en,
  input logic               clr_ref,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [ENTRIES-1:0] dirty_q,
  input logic [ENTRIES-1:0] ref_q
);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_hit, rsp_miss, rsp_fault}) == 32'(rsp_valid));

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  assert_no_rsp_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);

  assert_miss_zero_addr_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> rsp_paddr == '0);

  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_paddr == '0);

  assert_clear_refs_R8: assert property (@(posedge clk) disable iff (rst)
    clr_ref |=> ref_q == '0);

  assert_fault_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault && !$past(wr_en) && !$past(clr_ref)) |->
      (dirty_q == $past(dirty_q) && ref_q == $past(ref_q)));

  assert_dirty_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((dirty_q & $past(dirty_q)) == $past(dirty_q)));
endmodule

bind soft_tlb soft_tlb_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_req    (lk_req),
  .wr_en     (wr_en),
  .clr_ref   (clr_ref),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .dirty_q   (dirty_q),
  .ref_q     (ref_q)
);

// File: tb/test_soft_tlb.sv
`timescale 1ns/1ps
module test_soft_tlb;
  logic        clk = 0, rst = 1;
  logic        lk_req = 0;
  logic [14:0] lk_vaddr = 0;
  logic [1:0]  lk_kind = 0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [12:0] rsp_paddr;
  logic        wr_en = 0, wr_valid = 0, clr_ref = 0;
  logic [2:0]  wr_idx = 0, wr_ppn = 0, wr_rights = 0, rd_idx = 0;
  logic [4:0]  wr_vpn = 0;
  logic        rd_dirty, rd_ref;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  soft_tlb i_soft_tlb (.*);

  // behavioural reference state
  int  m_val[8], m_tag[8], m_ppn[8], m_rgt[8], m_dty[8], m_ref[8];
  int  e_valid, e_hit, e_miss, e_fault, e_paddr, e_rdd, e_rdr;

  always @(posedge clk) begin
    int  hit_i;
    bit  ok;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        m_val[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_rgt[i] = 0; m_dty[i] = 0; m_ref[i] = 0;
      end
      e_valid = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_paddr = 0; e_rdd = 0; e_rdr = 0;
    end else begin
      hit_i = -1;
      for (int i = 7; i >= 0; i--)
        if (m_val[i] != 0 && m_tag[i] == int'(lk_vaddr[14:10])) hit_i = i;
      ok = 0;
      if (hit_i >= 0 && lk_kind != 3) ok = ((m_rgt[hit_i] >> lk_kind) & 1) != 0;
      e_valid = lk_req;
      e_hit   = lk_req && hit_i >= 0 && ok;
      e_miss  = lk_req && hit_i < 0;
      e_fault = lk_req && hit_i >= 0 && !ok;
      e_paddr = e_hit ? m_ppn[hit_i] * 1024 + int'(lk_vaddr[9:0]) : 0;
      e_rdd   = m_dty[rd_idx];
      e_rdr   = m_ref[rd_idx];
      if (e_hit) begin
        m_ref[hit_i] = 1;
        if (lk_kind == 1) m_dty[hit_i] = 1;
      end
      if (clr_ref) for (int i = 0; i < 8; i++) m_ref[i] = 0;
      if (wr_en) begin
        m_val[wr_idx] = wr_valid; m_tag[wr_idx] = wr_vpn; m_ppn[wr_idx] = wr_ppn;
        m_rgt[wr_idx] = wr_rights; m_dty[wr_idx] = 0; m_ref[wr_idx] = 0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R11 valid", rsp_valid, e_valid);
      check("R2 hit",    rsp_hit,   e_hit);
      check("R3 miss",   rsp_miss,  e_miss);
      check("R4 fault",  rsp_fault, e_fault);
      check("R2 paddr",  rsp_paddr, e_paddr);
      check("R5 rd_dirty", rd_dirty, e_rdd);
      check("R6 rd_ref",   rd_ref,   e_rdr);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    lk_req = 0; wr_en = 0; clr_ref = 0;
  endtask

  task automatic install(int idx, int vpn, int ppn, int v, int rgt);
    wr_en = 1; wr_idx = idx[2:0]; wr_vpn = vpn[4:0]; wr_ppn = ppn[2:0];
    wr_valid = v[0]; wr_rights = rgt[2:0];
    tick(); idle();
  endtask

  // present a lookup, result visible after the next edge
  task automatic look(int vpn, int off, int kind);
    lk_req = 1; lk_vaddr = {vpn[4:0], off[9:0]}; lk_kind = kind[1:0];
    tick(); idle();
  endtask

  task automatic probe(int idx, output int d, output int r);
    rd_idx = idx[2:0]; tick(); d = rd_dirty; r = rd_ref;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d, r;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 paddr", rsp_paddr, 0);
    for (int i = 0; i < 8; i++) begin
      probe(i, d, r);
      check("R1 dirty", d, 0); check("R1 ref", r, 0);
    end
    look(3, 5, 0);
    check("R1 miss after reset", rsp_miss, 1);

    // R2 R3: hit and miss
    install(1, 3, 6, 1, 3'b001);
    look(3, 10'h2AB, 0);
    check("R2 hit", rsp_hit, 1);
    check("R2 paddr", rsp_paddr, 6 * 1024 + 'h2AB);
    look(4, 7, 0);
    check("R3 miss", rsp_miss, 1);
    check("R3 paddr zero", rsp_paddr, 0);
    install(2, 4, 2, 0, 3'b111);
    look(4, 7, 0);
    check("R3 invalid entry misses", rsp_miss, 1);

    // R4 R7: rights
    rd_idx = 1; tick();
    look(3, 1, 1);
    check("R4 write to read-only faults", rsp_fault, 1);
    check("R4 fault paddr zero", rsp_paddr, 0);
    look(3, 1, 2);
    check("R4 exec on read-only faults", rsp_fault, 1);
    look(3, 1, 3);
    check("R4 kind 3 faults", rsp_fault, 1);
    probe(1, d, r);
    check("R7 dirty after faults", d, 0);
    install(5, 9, 4, 1, 3'b100);
    look(9, 0, 0);
    check("R4 read on exec-only faults", rsp_fault, 1);
    probe(5, d, r);
    check("R7 ref after fault", r, 0);
    look(9, 3, 2);
    check("R4 exec allowed", rsp_hit, 1);

    // R5 R6: flags
    install(0, 12, 7, 1, 3'b011);
    look(12, 0, 0);
    probe(0, d, r); tick();
    probe(0, d, r);
    check("R5 read leaves dirty", d, 0);
    check("R6 ref set by read", r, 1);
    look(12, 4, 1);
    tick(); probe(0, d, r);
    check("R5 write sets dirty", d, 1);

    // R8: clear refs, including same-cycle hit
    clr_ref = 1; lk_req = 1; lk_vaddr = {5'd12, 10'd0}; lk_kind = 0;
    tick(); idle();
    tick(); probe(0, d, r);
    check("R8 ref cleared over hit", r, 0);
    check("R12 dirty kept", d, 1);

    // R9: duplicate tags
    install(6, 20, 1, 1, 3'b111);
    install(3, 20, 5, 1, 3'b111);
    look(20, 9, 1);
    check("R9 lowest index wins", rsp_paddr, 5 * 1024 + 9);
    tick(); probe(3, d, r);
    check("R9 low entry dirty", d, 1);
    probe(6, d, r);
    check("R9 high entry untouched", d, 0);

    // R10: install over same-cycle hit
    wr_en = 1; wr_idx = 3; wr_vpn = 21; wr_ppn = 2; wr_valid = 1; wr_rights = 3'b111;
    lk_req = 1; lk_vaddr = {5'd20, 10'd1}; lk_kind = 1;
    tick();
    check("R10 lookup sees old entry", rsp_paddr, 5 * 1024 + 1);
    idle(); tick(); probe(3, d, r);
    check("R10 install clears dirty", d, 0);
    check("R10 install clears ref", r, 0);
    look(21, 2, 0);
    check("R10 new mapping", rsp_paddr, 2 * 1024 + 2);

    // random traffic, compared every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      wr_en = ($urandom_range(0, 7) == 0);
      wr_idx = 3'($urandom); wr_vpn = 5'($urandom_range(0, 7)); wr_ppn = 3'($urandom);
      wr_valid = ($urandom_range(0, 4) != 0); wr_rights = 3'($urandom);
      clr_ref = ($urandom_range(0, 15) == 0);
      lk_req = ($urandom_range(0, 3) != 0);
      lk_vaddr = {5'($urandom_range(0, 7)), 10'($urandom)};
      lk_kind = 2'($urandom);
      rd_idx = 3'($urandom);
      tick();
    end
    idle();
    tick(); tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule